// File: doc/BRIEF.md
# Descriptor Ring Transmit DMA Channel

This block moves outgoing frames from system memory to a byte stream. Software builds a ring of two-word descriptors in memory. Each descriptor holds a status word and a buffer pointer. Software programs the ring base and ring length, then sets the enable bit. The channel walks the ring from its current index. For every descriptor that software has handed over, it reads the buffer through a 32-bit memory master port and presents the bytes on a ready/valid stream, with start and end markers. When the last byte has been taken, it writes the status word back with ownership returned to software and the complete bit set.

A frame may occupy one descriptor, with both the start and end bits set, or several consecutive descriptors. When the channel reaches a descriptor that software still holds, it clears its own enable bit and waits. Software sees that the channel has stopped, refills the ring and sets enable again. Fetching then resumes at the index where the channel stopped. A reset command is also provided. While the channel is idle, it returns the index to the first entry.

Top module: `txdma_ring_chan`

## Requirements
- R1: A descriptor occupies 8 bytes at ring_base + 8*index. The status word is at offset 0 and the buffer pointer at offset 4. The status word layout is: bit 31 owned-by-channel, bit 30 complete, bit 29 start-of-frame, bit 28 end-of-frame, bits 27:23 byte offset, bits 22:16 reserved, bits 15:0 byte count. The channel reads the pointer and sends data only when bit 31 is 1.
- R2: When a fetched status word has bit 31 equal to 0, the channel emits no byte and writes nothing for that descriptor. It clears its enable bit, so control bit 0 reads 0.
- R3: For an owned descriptor, the channel emits exactly byte-count bytes, in ascending address order, starting at byte address pointer + byte offset. Memory words are little-endian: the byte at an address with low bits 0 is word bits 7:0, and low bits 3 select bits 31:24.
- R4: tx_sop is 1 only on the first byte of a descriptor whose bit 29 is set. tx_eop is 1 only on its last byte when bit 28 is set.
- R5: After the last byte of a descriptor has been accepted, the channel writes the status word once to its own address. Bit 31 becomes 0, bit 30 becomes 1, and bits 29:0 are unchanged.
- R6: After each write-back the index advances by one. After entry ring_length-1 it wraps to 0.
- R7: Writing control with bit 0 = 1 and bit 1 = 0 to a stopped channel resumes fetching at the index where it stopped.
- R8: Writing control with bit 1 = 1 while the channel is idle sets the index to 0 and leaves the channel disabled. Bit 0 of that write is ignored.
- R9: While tx_valid is 1 and tx_ready is 0, tx_data, tx_sop and tx_eop hold their values and tx_valid stays 1.
- R10: After reset, tx_valid and mem_req are 0, and all three registers read 0.
- R11: Register addresses: 0 is the ring base, whose low 3 bits are dropped and read as 0. 1 is the ring length, in the low IDX_W bits. 2 is control, with bit 0 enable and bit 1 reset. Reads return the stored values, and control bit 1 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| mem_req | output | 1 | Memory request, held until granted |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word accessed |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid, at least one cycle after the grant |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Downstream accepts the byte |
| tx_data | output | 8 | Stream byte |
| tx_sop | output | 1 | First byte of a frame |
| tx_eop | output | 1 | Last byte of a frame |

## Verification
A register write takes effect at the clock edge that ends the write cycle, and reg_rdata follows reg_addr in the same cycle. The bench therefore reads registers one step after setting the address, away from the edge. Stream bytes and write-backs have no fixed latency, because they depend on grant timing and on tx_ready. The bench records each accepted byte, each granted write and each status-word read at the falling edge before the edge that completes the handshake. It compares those recordings against orderings computed from the descriptor table, and compares them only once the channel reports itself stopped through control bit 0. Holding during a stall is checked one cycle after every refused byte.

// File: rtl/txdma_pkg.sv
package txdma_pkg;

  localparam int AW    = 32;
  localparam int DW    = 32;
  localparam int CNT_W = 16;
  localparam int OFF_W = 5;

  typedef struct packed {
    logic             owned;
    logic             cmpl;
    logic             sof;
    logic             eof;
    logic [OFF_W-1:0] boff;
    logic [6:0]       rsvd;
    logic [CNT_W-1:0] count;
  } tx_stat_t;

  typedef enum logic [3:0] {
    E_IDLE, E_ST_REQ, E_ST_WAIT, E_PT_REQ, E_PT_WAIT,
    E_DAT_REQ, E_DAT_WAIT, E_STREAM, E_WB_REQ, E_NEXT
  } eng_state_e;

  function automatic logic [AW-1:0] slot_addr(logic [AW-1:0] base, logic [AW-1:0] idx,
                                              logic ptr_word);
    return base + (idx << 3) + (ptr_word ? 32'd4 : 32'd0);
  endfunction

  function automatic logic [AW-1:0] next_slot(logic [AW-1:0] idx, logic [AW-1:0] n);
    return ((idx + 32'd1) >= n) ? 32'd0 : idx + 32'd1;
  endfunction

  function automatic tx_stat_t retire(tx_stat_t s);
    tx_stat_t r;
    r       = s;
    r.owned = 1'b0;
    r.cmpl  = 1'b1;
    return r;
  endfunction

  function automatic logic [AW-1:0] first_byte(logic [AW-1:0] ptr, logic [OFF_W-1:0] off);
    return ptr + AW'(off);
  endfunction

  function automatic logic [AW-1:0] word_of(logic [AW-1:0] a);
    return {a[AW-1:2], 2'b00};
  endfunction

  function automatic logic [7:0] lane_pick(logic [DW-1:0] w, logic [1:0] sel);
    return w[{sel, 3'b000} +: 8];
  endfunction

endpackage

// File: rtl/txdma_regs.sv
module txdma_regs
  import txdma_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             eng_idle,
  input  logic             ev_stop,
  output logic [AW-1:0]    ring_base,
  output logic [IDX_W-1:0] ring_len,
  output logic             chan_en,
  output logic             idx_clear
);

  logic wr_base, wr_len, wr_ctrl;

  assign wr_base   = reg_we && (reg_addr == 2'd0);
  assign wr_len    = reg_we && (reg_addr == 2'd1);
  assign wr_ctrl   = reg_we && (reg_addr == 2'd2);
  assign idx_clear = wr_ctrl && reg_wdata[1] && eng_idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ring_base <= '0;
      ring_len  <= '0;
      chan_en   <= 1'b0;
    end else begin
      if (wr_base) ring_base <= {reg_wdata[AW-1:3], 3'b000};
      if (wr_len)  ring_len  <= reg_wdata[IDX_W-1:0];
      if (wr_ctrl && !reg_wdata[1]) chan_en <= reg_wdata[0];
      else if (idx_clear)           chan_en <= 1'b0;
      else if (ev_stop)             chan_en <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = ring_base;
      2'd1:    reg_rdata = {{(DW-IDX_W){1'b0}}, ring_len};
      2'd2:    reg_rdata = {{(DW-1){1'b0}}, chan_en};
      default: reg_rdata = '0;
    endcase
  end

  assert_stop_clears_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop && !wr_ctrl) |=> !chan_en);

  assert_clear_disables_R8: assert property (@(posedge clk) disable iff (!rst_n)
    idx_clear |=> !chan_en);

endmodule

// File: rtl/txdma_lane.sv
module txdma_lane
  import txdma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [AW-1:0]    load_addr,
  input  logic [CNT_W-1:0] load_cnt,
  input  logic             load_sof,
  input  logic             load_eof,
  input  logic             word_vld,
  input  logic [DW-1:0]    word_in,
  input  logic             tx_ready,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  output logic             tx_sop,
  output logic             tx_eop,
  output logic             need_word,
  output logic             seg_done,
  output logic [AW-1:0]    fetch_addr
);

  logic [AW-1:0]    cur_addr;
  logic [CNT_W-1:0] remain;
  logic [DW-1:0]    word_q;
  logic             have, first, sof_f, eof_f;
  logic             fire, last_b, wrap_b;

  assign fire       = have && tx_ready;
  assign last_b     = (remain == CNT_W'(1));
  assign wrap_b     = (cur_addr[1:0] == 2'd3);
  assign seg_done   = fire && last_b;
  assign need_word  = fire && !last_b && wrap_b;
  assign fetch_addr = word_of(cur_addr);

  assign tx_valid = have;
  assign tx_data  = lane_pick(word_q, cur_addr[1:0]);
  assign tx_sop   = have && sof_f && first;
  assign tx_eop   = have && eof_f && last_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr <= '0;
      remain   <= '0;
      word_q   <= '0;
      have     <= 1'b0;
      first    <= 1'b0;
      sof_f    <= 1'b0;
      eof_f    <= 1'b0;
    end else if (load) begin
      cur_addr <= load_addr;
      remain   <= load_cnt;
      first    <= 1'b1;
      sof_f    <= load_sof;
      eof_f    <= load_eof;
      have     <= 1'b0;
    end else if (word_vld) begin
      word_q <= word_in;
      have   <= 1'b1;
    end else if (fire) begin
      cur_addr <= cur_addr + 32'd1;
      remain   <= remain - CNT_W'(1);
      first    <= 1'b0;
      if (last_b || wrap_b) have <= 1'b0;
    end
  end

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_sop) && $stable(tx_eop)));

  assert_done_drops_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    seg_done |=> !tx_valid);

endmodule

// File: rtl/txdma_engine.sv
module txdma_engine
  import txdma_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    ring_base,
  input  logic [IDX_W-1:0] ring_len,
  input  logic             chan_en,
  input  logic             idx_clear,
  output logic             eng_idle,
  output logic             ev_stop,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic             mem_gnt,
  input  logic             mem_rvalid,
  input  logic [DW-1:0]    mem_rdata,
  output logic             ev_load,
  output logic [AW-1:0]    load_addr,
  output logic [CNT_W-1:0] load_cnt,
  output logic             load_sof,
  output logic             load_eof,
  output logic             word_vld,
  input  logic             need_word,
  input  logic             seg_done,
  input  logic [AW-1:0]    fetch_addr
);

  eng_state_e       st;
  tx_stat_t         stat_q, rd_stat;
  logic [IDX_W-1:0] idx;
  logic             ev_retire;

  assign rd_stat   = tx_stat_t'(mem_rdata);
  assign eng_idle  = (st == E_IDLE);
  assign ev_stop   = (st == E_ST_WAIT) && mem_rvalid && !rd_stat.owned;
  assign ev_load   = (st == E_PT_WAIT) && mem_rvalid;
  assign word_vld  = (st == E_DAT_WAIT) && mem_rvalid;
  assign ev_retire = (st == E_WB_REQ) && mem_gnt;
  assign load_addr = first_byte(mem_rdata, stat_q.boff);
  assign load_cnt  = stat_q.count;
  assign load_sof  = stat_q.sof;
  assign load_eof  = stat_q.eof;

  assign mem_req   = (st == E_ST_REQ) || (st == E_PT_REQ) || (st == E_DAT_REQ) || (st == E_WB_REQ);
  assign mem_we    = (st == E_WB_REQ);
  assign mem_wdata = retire(stat_q);

  always_comb begin
    case (st)
      E_PT_REQ:  mem_addr = slot_addr(ring_base, AW'(idx), 1'b1);
      E_DAT_REQ: mem_addr = fetch_addr;
      default:   mem_addr = slot_addr(ring_base, AW'(idx), 1'b0);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= E_IDLE;
      stat_q <= '0;
      idx    <= '0;
    end else begin
      case (st)
        E_IDLE: begin
          if (idx_clear)    idx <= '0;
          else if (chan_en) st  <= E_ST_REQ;
        end
        E_ST_REQ:  if (mem_gnt) st <= E_ST_WAIT;
        E_ST_WAIT: begin
          if (mem_rvalid) begin
            stat_q <= rd_stat;
            st     <= rd_stat.owned ? E_PT_REQ : E_IDLE;
          end
        end
        E_PT_REQ:  if (mem_gnt) st <= E_PT_WAIT;
        E_PT_WAIT: begin
          if (mem_rvalid) st <= (stat_q.count == '0) ? E_WB_REQ : E_DAT_REQ;
        end
        E_DAT_REQ:  if (mem_gnt) st <= E_DAT_WAIT;
        E_DAT_WAIT: if (mem_rvalid) st <= E_STREAM;
        E_STREAM: begin
          if (seg_done)       st <= E_WB_REQ;
          else if (need_word) st <= E_DAT_REQ;
        end
        E_WB_REQ: if (mem_gnt) st <= E_NEXT;
        E_NEXT: begin
          idx <= IDX_W'(next_slot(AW'(idx), AW'(ring_len)));
          st  <= chan_en ? E_ST_REQ : E_IDLE;
        end
        default: st <= E_IDLE;
      endcase
    end
  end

  assert_retire_owned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_retire |-> stat_q.owned);

  assert_idx_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (idx != $past(idx)) |-> ((idx == '0) || (idx == $past(idx) + IDX_W'(1))));

  assert_no_data_unowned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> !mem_req);

endmodule

// File: rtl/txdma_ring_chan.sv
module txdma_ring_chan
  import txdma_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [31:0]   mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_gnt,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_sop,
  output logic          tx_eop
);

  logic [AW-1:0]    ring_base;
  logic [IDX_W-1:0] ring_len;
  logic             chan_en, idx_clear, eng_idle, ev_stop;
  logic             ev_load, load_sof, load_eof, word_vld, need_word, seg_done;
  logic [AW-1:0]    load_addr, fetch_addr;
  logic [CNT_W-1:0] load_cnt;

  txdma_regs #(.IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_idle(eng_idle),
    .ev_stop(ev_stop), .ring_base(ring_base), .ring_len(ring_len),
    .chan_en(chan_en), .idx_clear(idx_clear)
  );

  txdma_engine #(.IDX_W(IDX_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .ring_len(ring_len),
    .chan_en(chan_en), .idx_clear(idx_clear), .eng_idle(eng_idle),
    .ev_stop(ev_stop), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .ev_load(ev_load),
    .load_addr(load_addr), .load_cnt(load_cnt), .load_sof(load_sof),
    .load_eof(load_eof), .word_vld(word_vld), .need_word(need_word),
    .seg_done(seg_done), .fetch_addr(fetch_addr)
  );

  txdma_lane u_lane (
    .clk(clk), .rst_n(rst_n), .load(ev_load), .load_addr(load_addr),
    .load_cnt(load_cnt), .load_sof(load_sof), .load_eof(load_eof),
    .word_vld(word_vld), .word_in(mem_rdata), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_sop(tx_sop),
    .tx_eop(tx_eop), .need_word(need_word), .seg_done(seg_done),
    .fetch_addr(fetch_addr)
  );

  assert_port_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_req, tx_valid}));

endmodule

// File: tb/txdma_ring_chan_tb.sv
module txdma_ring_chan_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_gnt = 1'b0, mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        tx_valid, tx_sop, tx_eop;
  logic        tx_ready = 1'b0;
  logic [7:0]  tx_data;

  always #4 clk = ~clk;

  txdma_ring_chan #(.IDX_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_sop(tx_sop), .tx_eop(tx_eop)
  );

  localparam int RING = 4;
  localparam logic [31:0] BASE = 32'h100;

  typedef struct packed {
    int unsigned batch;
    int unsigned slot;
    logic [31:0] ptr;
    logic [4:0]  off;
    logic [15:0] cnt;
    logic        sof;
    logic        eof;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{0, 0, 32'h400, 5'd3,  16'd5,  1'b1, 1'b0},
    '{0, 1, 32'h500, 5'd0,  16'd9,  1'b0, 1'b1},
    '{0, 2, 32'h600, 5'd31, 16'd1,  1'b1, 1'b1},
    '{1, 3, 32'h700, 5'd6,  16'd13, 1'b1, 1'b1},
    '{1, 0, 32'h440, 5'd1,  16'd2,  1'b1, 1'b1},
    '{2, 0, 32'h480, 5'd2,  16'd20, 1'b1, 1'b1}
  };

  logic [31:0] mem [0:1023];
  logic [9:0]  rx_q [$];
  logic [63:0] wb_q [$];
  logic [31:0] st_q [$];
  int n_chk = 0, n_bad = 0;
  int stall_seen = 0, stall_bad = 0;
  bit timed_out = 0;

  function automatic logic [7:0] byte_at(int unsigned a);
    return 8'((a * 37 + 11) ^ (a >> 5));
  endfunction

  function automatic logic [31:0] stat_of(vec_t v);
    return {1'b1, 1'b0, v.sof, v.eof, v.off, 7'h00, v.cnt};
  endfunction

  task automatic chk(bit ok, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // memory model: grants two of every three cycles, read data two cycles after grant
  initial begin
    int pend = 0;
    int gcnt = 0;
    logic [31:0] pdata = '0;
    forever begin
      @(negedge clk);
      mem_gnt    = 1'b0;
      mem_rvalid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          mem_rvalid = 1'b1;
          mem_rdata  = pdata;
        end
      end else if (rst_n && mem_req && (gcnt % 3 != 0)) begin
        mem_gnt = 1'b1;
        if (mem_we) begin
          mem[mem_addr[11:2]] = mem_wdata;
          wb_q.push_back({mem_addr, mem_wdata});
        end else begin
          pdata = mem[mem_addr[11:2]];
          pend  = 2;
          if (mem_addr[2:0] == 3'd0 && mem_addr >= BASE && mem_addr < BASE + 32'd64)
            st_q.push_back(mem_addr);
        end
      end
      gcnt++;
    end
  end

  // stream sink with a stalling ready pattern; records accepted bytes
  initial begin
    int rc = 0;
    bit hold = 0;
    logic [9:0] hv = '0;
    forever begin
      @(negedge clk);
      rc++;
      tx_ready = (rc % 5 != 1) && (rc % 7 != 3);
      if (hold) begin
        stall_seen++;
        if (!tx_valid || {tx_sop, tx_eop, tx_data} != hv) stall_bad++;
      end
      hold = rst_n && tx_valid && !tx_ready;
      hv   = {tx_sop, tx_eop, tx_data};
      if (rst_n && tx_valid && tx_ready) rx_q.push_back({tx_sop, tx_eop, tx_data});
    end
  end

  task automatic reg_write(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_wdata = d;
    reg_we    = 1'b1;
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  task automatic reg_read(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_stop();
    logic [31:0] c;
    int guard = 0;
    do begin
      reg_read(2'd2, c);
      guard++;
    end while (c[0] && guard < 20000);
    repeat (4) @(negedge clk);
  endtask

  task automatic check_desc(int i);
    int bad_d = 0, bad_f = 0;
    logic [9:0] item;
    logic [7:0] ed, ad = '0, fe = '0;
    logic [1:0] ef, af = '0, ffe = '0;
    for (int k = 0; k < int'(VEC[i].cnt); k++) begin
      ed = byte_at(VEC[i].ptr + VEC[i].off + k);
      ef = {VEC[i].sof && (k == 0), VEC[i].eof && (k == int'(VEC[i].cnt) - 1)};
      if (rx_q.size() == 0) begin
        bad_d++;
        bad_f++;
      end else begin
        item = rx_q.pop_front();
        if (item[7:0] != ed && bad_d == 0) begin ad = item[7:0]; fe = ed; end
        if (item[7:0] != ed) bad_d++;
        if (item[9:8] != ef && bad_f == 0) begin af = item[9:8]; ffe = ef; end
        if (item[9:8] != ef) bad_f++;
      end
    end
    chk(bad_d == 0, $sformatf("R3 bytes of descriptor %0d", i), 64'(ad), 64'(fe));
    chk(bad_f == 0, $sformatf("R4 sop/eop of descriptor %0d", i), 64'(af), 64'(ffe));
  endtask

  task automatic run_all();
    logic [31:0] r;
    logic [63:0] w;
    logic [31:0] sa;
    int last_slot;
    int first_i;

    for (int a = 0; a < 1024; a++)
      mem[a] = {byte_at(4*a+3), byte_at(4*a+2), byte_at(4*a+1), byte_at(4*a)};
    for (int a = 0; a < 16; a++) mem[(BASE >> 2) + a] = '0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(!tx_valid, "R10 tx_valid after reset", 64'(tx_valid), 0);
    chk(!mem_req, "R10 mem_req after reset", 64'(mem_req), 0);
    for (int a = 0; a < 3; a++) begin
      reg_read(2'(a), r);
      chk(r == 0, $sformatf("R10 register %0d after reset", a), 64'(r), 0);
    end

    // R11 register map
    reg_write(2'd0, BASE | 32'h5);
    reg_write(2'd1, RING);
    reg_read(2'd0, r);
    chk(r == BASE, "R11 base readback drops low bits", 64'(r), 64'(BASE));
    reg_read(2'd1, r);
    chk(r == RING, "R11 length readback", 64'(r), RING);

    for (int b = 0; b < 3; b++) begin
      if (b == 2) begin
        // R8 reset bit while idle, with bit 0 also set
        reg_write(2'd2, 32'h3);
        reg_read(2'd2, r);
        chk(r == 0, "R8 reset leaves channel disabled", 64'(r), 0);
      end
      last_slot = 0;
      first_i = -1;
      for (int i = 0; i < NV; i++) if (VEC[i].batch == b) begin
        mem[(BASE >> 2) + 2*VEC[i].slot]     = stat_of(VEC[i]);
        mem[(BASE >> 2) + 2*VEC[i].slot + 1] = VEC[i].ptr;
        last_slot = VEC[i].slot;
        if (first_i < 0) first_i = i;
      end
      st_q.delete();
      wb_q.delete();
      reg_write(2'd2, 32'h1);
      wait_stop();

      reg_read(2'd2, r);
      chk(r[0] == 1'b0, $sformatf("R2 channel stopped after batch %0d", b), 64'(r), 0);

      // status fetch order: R1 addressing, R6 wrap, R7 resume, R8 restart at 0
      for (int i = 0; i < NV; i++) if (VEC[i].batch == b) begin
        sa = BASE + 32'(8 * VEC[i].slot);
        r  = (st_q.size() > 0) ? st_q.pop_front() : 32'hFFFF_FFFF;
        chk(r == sa, $sformatf("R1 R6 R7 R8 status fetch for descriptor %0d", i), 64'(r), 64'(sa));
      end
      sa = BASE + 32'(8 * ((last_slot + 1) % RING));
      r  = (st_q.size() > 0) ? st_q.pop_front() : 32'hFFFF_FFFF;
      chk(r == sa, $sformatf("R2 R6 stop slot fetch, batch %0d", b), 64'(r), 64'(sa));
      chk(st_q.size() == 0, $sformatf("R2 no fetch past stop, batch %0d", b), 64'(st_q.size()), 0);

      for (int i = 0; i < NV; i++) if (VEC[i].batch == b) begin
        check_desc(i);
        sa = BASE + 32'(8 * VEC[i].slot);
        w  = (wb_q.size() > 0) ? wb_q.pop_front() : 64'hFFFF_FFFF_FFFF_FFFF;
        chk(w == {sa, 2'b01, stat_of(VEC[i])[29:0]},
            $sformatf("R5 write-back of descriptor %0d", i), w, {sa, 2'b01, stat_of(VEC[i])[29:0]});
      end
      chk(rx_q.size() == 0, $sformatf("R2 no bytes from unowned slot, batch %0d", b), 64'(rx_q.size()), 0);
      chk(wb_q.size() == 0, $sformatf("R2 no write to unowned slot, batch %0d", b), 64'(wb_q.size()), 0);
    end

    chk(stall_seen > 0 && stall_bad == 0, "R9 output held while stalled",
        64'(stall_bad), 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    if (timed_out) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
    end
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule